// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps the address reservations that load-locked reads leave behind, for a set of execution contexts that share one memory port. Each cycle at most one request arrives, carrying an operation (load-locked, plain store or conditional store), the context that issued it and a byte address. The block answers in the same cycle. It says whether a store may write memory, and for a conditional store whether it won its reservation. Its reservation table changes on the next clock edge.

Addresses are reduced to 64-byte granules before they are stored or compared. A context owns at most one reservation at any time. A write that is allowed to proceed removes the reservations of every context on that granule. A conditional store that loses leaves the table exactly as it was. The table has `NUM_SLOTS` entries. When all of them are taken, a load-locked from a context that has no entry evicts the slot named by a round-robin victim pointer.

Top module: `llsc_monitor`

## Requirements
- R1: Only address bits [31:6] (the 64-byte granule) are stored and compared. Two addresses that differ only in bits [5:0] are treated as the same location.
- R2: A load-locked (op 2'b00) from a context that already has an entry rewrites that entry's granule and creates no second entry. The context's earlier granule is then no longer reserved.
- R3: A load-locked from a context with no entry fills the lowest-numbered free slot. If no slot is free, it replaces the slot at the victim pointer, and the pointer then advances by one, wrapping modulo NUM_SLOTS.
- R4: A plain store (op 2'b01) raises `wr_grant` in the same cycle, unconditionally.
- R5: A conditional store (op 2'b10) raises both `wr_grant` and `sc_pass` in its own cycle exactly when a valid entry matches both its context and its granule. Otherwise both outputs stay 0.
- R6: A conditional store that fails leaves every entry unchanged.
- R7: A granted write, plain or conditional, invalidates at the next clock edge every entry on the same granule, whichever context owns it.
- R8: An idle cycle (`req_valid` low) and the reserved op code 2'b11 both drive 0 on both outputs and leave the table unchanged.
- R9: Synchronous active-high reset empties the table and returns the victim pointer to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 load-locked, 01 plain store, 10 conditional store, 11 reserved |
| req_ctx | input | 3 | Issuing context ID |
| req_addr | input | 32 | Byte address of the access |
| wr_grant | output | 1 | The store may write memory (combinational) |
| sc_pass | output | 1 | The conditional store succeeded (combinational) |

## Verification
The checker assumes that at most one request arrives per cycle and that the request inputs are stable around the rising edge. It also assumes that `req_ctx` and `req_op` carry known values whenever `req_valid` is high. The bench changes inputs only on falling edges, and it drives a defined op, context and address with every request, including the reserved op code. The random phase draws addresses from three granules and randomises the offsets inside each granule. Contexts range over all eight IDs, which is more than the four slots, so the full-table eviction path is taken often while the checker's invariants keep holding.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    localparam int ADDR_W   = 32;
    localparam int CTX_W    = 3;
    localparam int GRAN_LSB = 6;
    localparam int GRAN_W   = ADDR_W - GRAN_LSB;

    typedef enum logic [1:0] {
        OP_LL   = 2'b00,
        OP_ST   = 2'b01,
        OP_SC   = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef struct packed {
        logic              vld;
        logic [CTX_W-1:0]  ctx;
        logic [GRAN_W-1:0] gran;
    } resv_t;

    function automatic logic [GRAN_W-1:0] to_gran(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:GRAN_LSB];
    endfunction
endpackage

// File: rtl/llsc_match.sv
module llsc_match
    import llsc_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  resv_t [NUM_SLOTS-1:0] tbl,
    input  logic [CTX_W-1:0]      ctx,
    input  logic [GRAN_W-1:0]     gran,
    output logic [NUM_SLOTS-1:0]  ctx_hit,
    output logic [NUM_SLOTS-1:0]  gran_hit,
    output logic [NUM_SLOTS-1:0]  free
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign ctx_hit[i]  = tbl[i].vld && (tbl[i].ctx == ctx);
        assign gran_hit[i] = tbl[i].vld && (tbl[i].gran == gran);
        assign free[i]     = !tbl[i].vld;
    end
endmodule

// File: rtl/llsc_alloc.sv
module llsc_alloc #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_req,
    input  logic [NUM_SLOTS-1:0] ctx_hit,
    input  logic [NUM_SLOTS-1:0] free,
    output logic [SLOT_W-1:0]    slot,
    output logic [SLOT_W-1:0]    victim
);
    logic [SLOT_W-1:0] own_idx, free_idx;
    logic              evict;

    always_comb begin
        own_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--)
            if (ctx_hit[i]) own_idx = SLOT_W'(i);
    end

    always_comb begin
        free_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--)
            if (free[i]) free_idx = SLOT_W'(i);
    end

    assign evict = alloc_req && !(|ctx_hit) && !(|free);

    always_comb begin
        if (|ctx_hit)   slot = own_idx;
        else if (|free) slot = free_idx;
        else            slot = victim;
    end

    always_ff @(posedge clk) begin
        if (rst)
            victim <= '0;
        else if (evict)
            victim <= (victim == SLOT_W'(NUM_SLOTS - 1)) ? '0 : victim + 1'b1;
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              wr_grant,
    output logic              sc_pass
);
    resv_t [NUM_SLOTS-1:0] tbl;
    logic  [NUM_SLOTS-1:0] ctx_hit, gran_hit, free;
    logic  [GRAN_W-1:0]    gran;
    logic  [SLOT_W-1:0]    slot, victim;
    op_e                   op;
    logic                  is_ll, is_st, is_sc, sc_hit;

    assign gran  = to_gran(req_addr);
    assign op    = op_e'(req_op);
    assign is_ll = req_valid && (op == OP_LL);
    assign is_st = req_valid && (op == OP_ST);
    assign is_sc = req_valid && (op == OP_SC);

    llsc_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .tbl      (tbl),
        .ctx      (req_ctx),
        .gran     (gran),
        .ctx_hit  (ctx_hit),
        .gran_hit (gran_hit),
        .free     (free)
    );

    llsc_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (is_ll),
        .ctx_hit   (ctx_hit),
        .free      (free),
        .slot      (slot),
        .victim    (victim)
    );

    assign sc_hit   = |(ctx_hit & gran_hit);
    assign sc_pass  = is_sc && sc_hit;
    assign wr_grant = is_st || sc_pass;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
        end else if (is_ll) begin
            tbl[slot] <= '{vld: 1'b1, ctx: req_ctx, gran: gran};
        end else if (wr_grant) begin
            for (int i = 0; i < NUM_SLOTS; i++)
                if (gran_hit[i]) tbl[i].vld <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [1:0]            req_op,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  wr_grant,
    input logic                  sc_pass,
    input resv_t [NUM_SLOTS-1:0] tbl
);
    logic              last_grant;
    logic [GRAN_W-1:0] last_gran;
    logic              stale_left, dup_ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_grant <= 1'b0;
            last_gran  <= '0;
        end else begin
            last_grant <= wr_grant;
            last_gran  <= to_gran(req_addr);
        end
    end

    always_comb begin
        stale_left = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (tbl[i].vld && tbl[i].gran == last_gran) stale_left = 1'b1;
    end

    always_comb begin
        dup_ctx = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++)
            for (int j = i + 1; j < NUM_SLOTS; j++)
                if (tbl[i].vld && tbl[j].vld && tbl[i].ctx == tbl[j].ctx) dup_ctx = 1'b1;
    end

    AST_STORE_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b01) |-> wr_grant); // R4
    AST_PASS_ONLY_SC: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> (wr_grant && req_valid && req_op == 2'b10)); // R5
    AST_SC_FAIL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && !sc_pass) |=> $stable(tbl)); // R6
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        last_grant |-> !stale_left); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == 2'b11) |-> (!wr_grant && !sc_pass)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == 2'b11) |=> $stable(tbl)); // R8
    AST_ONE_PER_CTX: assert property (@(posedge clk) disable iff (rst)
        !dup_ctx); // R2
endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .wr_grant  (wr_grant),
    .sc_pass   (sc_pass),
    .tbl       (tbl)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [2:0]  req_ctx = '0;
    logic [31:0] req_addr = '0;
    logic        wr_grant, sc_pass;

    always #10 clk = ~clk;

    llsc_monitor #(.NUM_SLOTS(NS)) dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_ctx (req_ctx), .req_addr (req_addr),
        .wr_grant (wr_grant), .sc_pass (sc_pass)
    );

    typedef struct {
        logic  grant;
        logic  pass;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    bit          m_vld[NS];
    logic [2:0]  m_ctx[NS];
    logic [25:0] m_gran[NS];
    int          m_rr;

    task automatic model_reset();
        for (int i = 0; i < NS; i++) m_vld[i] = 0;
        m_rr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive(input bit v, input logic [1:0] o, input logic [2:0] c,
                         input logic [31:0] a, input string tag);
        exp_t e;
        logic [25:0] g = a[31:6];
        bit hit = 0;
        int slot = -1;
        @(negedge clk);
        req_valid = v; req_op = o; req_ctx = c; req_addr = a;
        for (int i = 0; i < NS; i++)
            if (m_vld[i] && m_ctx[i] == c && m_gran[i] == g) hit = 1;
        e.pass  = v && o == 2'b10 && hit;
        e.grant = (v && o == 2'b01) || e.pass;
        e.tag   = tag;
        q.push_back(e);
        if (v && o == 2'b00) begin
            for (int i = NS - 1; i >= 0; i--) if (m_vld[i] && m_ctx[i] == c) slot = i;
            if (slot < 0) for (int i = NS - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
            if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % NS; end
            m_vld[slot] = 1; m_ctx[slot] = c; m_gran[slot] = g;
        end else if (e.grant) begin
            for (int i = 0; i < NS; i++) if (m_vld[i] && m_gran[i] == g) m_vld[i] = 0;
        end
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 2'b00, 3'd0, 32'h0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (wr_grant !== e.grant || sc_pass !== e.pass) begin
                    errors++;
                    $display("FAIL %s: grant/pass actual=%b%b expected=%b%b",
                             e.tag, wr_grant, sc_pass, e.grant, e.pass);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        model_reset();
        do_reset();
        // R9: empty after reset, idle is quiet
        idle("R9 idle after reset");
        drive(1, 2'b10, 3'd0, 32'h0000_0000, "R9 SC on empty table");
        // R1 and R5: same granule, different offset
        drive(1, 2'b00, 3'd1, 32'h0000_1000, "R1 LL");
        drive(1, 2'b10, 3'd1, 32'h0000_1038, "R1 SC same granule passes");
        drive(1, 2'b10, 3'd1, 32'h0000_1000, "R7 own SC cleared entry");
        // R2: overwrite
        drive(1, 2'b00, 3'd1, 32'h0000_2000, "R2 LL first");
        drive(1, 2'b00, 3'd1, 32'h0000_3000, "R2 LL overwrite");
        drive(1, 2'b10, 3'd1, 32'h0000_2000, "R2 old granule gone");
        drive(1, 2'b10, 3'd1, 32'h0000_3004, "R2 new granule held");
        // R4/R7: plain store clears all contexts
        drive(1, 2'b00, 3'd2, 32'h0000_4000, "R7 LL ctx2");
        drive(1, 2'b00, 3'd3, 32'h0000_4010, "R7 LL ctx3");
        drive(1, 2'b01, 3'd0, 32'h0000_403c, "R4 plain store granted");
        drive(1, 2'b10, 3'd2, 32'h0000_4000, "R7 ctx2 cleared");
        drive(1, 2'b10, 3'd3, 32'h0000_4000, "R7 ctx3 cleared");
        // R5/R6: failed SC keeps reservations
        drive(1, 2'b00, 3'd2, 32'h0000_5000, "R6 LL ctx2");
        drive(1, 2'b00, 3'd3, 32'h0000_6000, "R6 LL ctx3");
        drive(1, 2'b10, 3'd3, 32'h0000_5000, "R5 SC wrong granule fails");
        drive(1, 2'b10, 3'd4, 32'h0000_5000, "R5 SC wrong context fails");
        drive(1, 2'b10, 3'd2, 32'h0000_5000, "R6 ctx2 kept after failed SC");
        drive(1, 2'b10, 3'd3, 32'h0000_6000, "R6 ctx3 kept after failed SC");
        // R8: reserved op and idle have no effect
        drive(1, 2'b00, 3'd5, 32'h0000_7000, "R8 LL ctx5");
        drive(1, 2'b11, 3'd5, 32'h0000_7000, "R8 reserved op quiet");
        drive(0, 2'b01, 3'd5, 32'h0000_7000, "R8 invalid store quiet");
        drive(1, 2'b10, 3'd5, 32'h0000_7000, "R8 reservation survived");
        // R3: fill table then evict by victim pointer
        do_reset();
        for (int c = 0; c < 4; c++) drive(1, 2'b00, 3'(c), 32'h0001_0000 + 32'(c) * 64, "R3 fill");
        drive(1, 2'b00, 3'd6, 32'h0002_0000, "R3 evict slot0");
        drive(1, 2'b00, 3'd7, 32'h0002_0040, "R3 evict slot1");
        drive(1, 2'b10, 3'd0, 32'h0001_0000, "R3 ctx0 evicted");
        drive(1, 2'b10, 3'd1, 32'h0001_0040, "R3 ctx1 evicted");
        drive(1, 2'b10, 3'd2, 32'h0001_0080, "R3 ctx2 kept");
        drive(1, 2'b10, 3'd6, 32'h0002_0000, "R3 ctx6 holds");
        drive(1, 2'b00, 3'd4, 32'h0003_0000, "R3 lowest free slot");
        drive(1, 2'b10, 3'd7, 32'h0002_0040, "R3 ctx7 holds");
        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [1:0]  o = 2'($urandom_range(0, 3));
            logic [2:0]  c = 3'($urandom_range(0, 7));
            logic [31:0] a = 32'h0000_8000 + 32'($urandom_range(0, 2)) * 64 + 32'($urandom_range(0, 63));
            drive($urandom_range(0, 7) != 0, o, c, a, "R5 R3 R7 random");
        end
        idle("R8 final idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule